// File: doc/BRIEF.md
# Video Illegal Code Remapper

This block sits in the 10-bit receive data path of a serial digital video receiver, after the timing extractor. It cleans up sample values that no legal picture word may carry. Inside the active picture, a word in the upper reserved band is pulled down to the highest legal code. A word in the lower reserved band is pulled up to the lowest legal code. Timing reference and ancillary preamble words that arrive in 8-bit form are widened to their full 10-bit form.

The upstream timing extractor marks active-picture words and preamble positions with two flags that travel alongside each word and its valid strobe. The correction is turned on when the local disable bit is LOW and the global processing-enable input is HIGH. If either condition fails, every word passes through untouched. The corrected word, the valid strobe and both flags leave the block one clock after they enter.

Top module: `vid_code_remap`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid, outActive and outPreamble are 0 and outWord is 000h.
- R2: With correction on, an active-picture word (inActive=1, inPreamble=0) from 3FCh to 3FFh leaves as 3FBh.
- R3: With correction on, an active-picture word from 000h to 003h leaves as 004h.
- R4: With correction on, an active-picture word from 004h to 3FBh leaves unchanged.
- R5: With correction on, a word at a preamble position (inPreamble=1) from 3FCh to 3FFh leaves as 3FFh.
- R6: With correction on, a preamble-position word from 000h to 003h leaves as 000h, and any other preamble-position word leaves unchanged.
- R7: When inPreamble and inActive are both 1, the preamble rule (R5, R6) applies and the active-picture rule does not.
- R8: A word with both flags 0 leaves unchanged for every one of the 1024 codes.
- R9: With remapDisable HIGH, every word leaves unchanged whatever its flags.
- R10: With procEn LOW, every word leaves unchanged whatever the level of remapDisable.
- R11: Latency is exactly one clock: outWord, outValid, outActive and outPreamble show the values of the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procEn | input | 1 | Global processing enable; HIGH lets remapDisable take effect |
| remapDisable | input | 1 | Local control bit; LOW turns correction on |
| inWord | input | 10 | Incoming video word |
| inValid | input | 1 | Incoming word is valid |
| inActive | input | 1 | Word lies in the active picture |
| inPreamble | input | 1 | Word sits at a timing-reference or ancillary preamble position |
| outWord | output | 10 | Corrected word, one clock later |
| outValid | output | 1 | Delayed inValid |
| outActive | output | 1 | Delayed inActive |
| outPreamble | output | 1 | Delayed inPreamble |

## Verification
The active-picture clamp and the preamble widening can both apply to one word when the extractor raises both flags in the same cycle. The two rules disagree on what happens to both reserved bands. The bench sweeps all 1024 codes with both flags set and expects the preamble results: 3FFh for the upper band and 000h for the lower band, never 3FBh or 004h. It runs the same sweep with each flag alone, and again with the correction turned off through each of its two controls, so that any wrong priority or leaked enable shows up as a wrong word.

// File: rtl/vid_code_remap_pkg.sv
package vid_code_remap_pkg;

  // Strobes from control to datapath: which rule applies this cycle.
  typedef struct packed {
    logic fixPreamble;  // widen 8-bit preamble code to 10-bit form
    logic fixActive;    // clamp reserved codes inside active picture
  } remapStrobeT;

endpackage

// File: rtl/vid_code_remap_ctrl.sv
module vid_code_remap_ctrl
  import vid_code_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procEn,
  input  logic        remapDisable,
  input  logic        inValid,
  input  logic        inActive,
  input  logic        inPreamble,
  output remapStrobeT strobes,
  output logic        outValid,
  output logic        outActive,
  output logic        outPreamble
);

  logic corrOn;

  // The local bit is active-low and only counts when processing is enabled.
  assign corrOn = procEn & ~remapDisable;

  // Preamble positions take priority over active-picture clamping.
  always_comb begin
    strobes             = '0;
    strobes.fixPreamble = corrOn & inPreamble;
    strobes.fixActive   = corrOn & inActive & ~inPreamble;
  end

  // Side-band flags are delayed to line up with the registered word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outActive   <= 1'b0;
      outPreamble <= 1'b0;
    end else begin
      outValid    <= inValid;
      outActive   <= inActive;
      outPreamble <= inPreamble;
    end
  end

endmodule

// File: rtl/vid_code_remap_dp.sv
module vid_code_remap_dp
  import vid_code_remap_pkg::*;
#(
  parameter int WORD_W        = 10,
  parameter int RESERVED_SPAN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  remapStrobeT       strobes,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] outWord
);

  localparam logic [WORD_W-1:0] CODE_MAX   = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] CODE_MIN   = '0;
  localparam logic [WORD_W-1:0] HIGH_START = CODE_MAX - WORD_W'(RESERVED_SPAN - 1);
  localparam logic [WORD_W-1:0] LOW_END    = WORD_W'(RESERVED_SPAN - 1);
  localparam logic [WORD_W-1:0] LEGAL_MAX  = HIGH_START - WORD_W'(1);
  localparam logic [WORD_W-1:0] LEGAL_MIN  = LOW_END + WORD_W'(1);

  logic              inHighBand;
  logic              inLowBand;
  logic [WORD_W-1:0] nextWord;

  assign inHighBand = (inWord >= HIGH_START);
  assign inLowBand  = (inWord <= LOW_END);

  always_comb begin
    nextWord = inWord;
    if (strobes.fixPreamble) begin
      if (inHighBand)     nextWord = CODE_MAX;
      else if (inLowBand) nextWord = CODE_MIN;
    end else if (strobes.fixActive) begin
      if (inHighBand)     nextWord = LEGAL_MAX;
      else if (inLowBand) nextWord = LEGAL_MIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outWord <= '0;
    else       outWord <= nextWord;
  end

endmodule

// File: rtl/vid_code_remap.sv
module vid_code_remap
  import vid_code_remap_pkg::*;
#(
  parameter int WORD_W        = 10,
  parameter int RESERVED_SPAN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procEn,
  input  logic              remapDisable,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              inActive,
  input  logic              inPreamble,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              outActive,
  output logic              outPreamble
);

  remapStrobeT strobes;

  vid_code_remap_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procEn      (procEn),
    .remapDisable(remapDisable),
    .inValid     (inValid),
    .inActive    (inActive),
    .inPreamble  (inPreamble),
    .strobes     (strobes),
    .outValid    (outValid),
    .outActive   (outActive),
    .outPreamble (outPreamble)
  );

  vid_code_remap_dp #(
    .WORD_W       (WORD_W),
    .RESERVED_SPAN(RESERVED_SPAN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inWord (inWord),
    .outWord(outWord)
  );

endmodule

// File: rtl/vid_code_remap_chk.sv
module vid_code_remap_chk #(
  parameter int WORD_W        = 10,
  parameter int RESERVED_SPAN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              procEn,
  input logic              remapDisable,
  input logic [WORD_W-1:0] inWord,
  input logic              inValid,
  input logic              inActive,
  input logic              inPreamble,
  input logic [WORD_W-1:0] outWord,
  input logic              outValid,
  input logic              outActive,
  input logic              outPreamble
);

  localparam logic [WORD_W-1:0] CODE_MAX   = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] HIGH_START = CODE_MAX - WORD_W'(RESERVED_SPAN - 1);
  localparam logic [WORD_W-1:0] LOW_END    = WORD_W'(RESERVED_SPAN - 1);

  // primed is set once a full clock has passed with reset released,
  // so every $past below refers to a post-reset sample.
  logic primed;
  always_ff @(posedge clk) primed <= rstN;

  logic corrOn;
  assign corrOn = procEn & ~remapDisable;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outActive && !outPreamble && outWord == '0));

  // R11
  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (outValid == $past(inValid)) && (outActive == $past(inActive)) &&
    (outPreamble == $past(inPreamble)));

  // R2 R3 R4: active-picture output never lands in a reserved band
  p_active_legal_r2: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(corrOn && inActive && !inPreamble) |->
      (outWord < HIGH_START) && (outWord > LOW_END));

  // R5 R7
  p_preamble_high_r5: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(corrOn && inPreamble && inWord >= HIGH_START) |-> outWord == CODE_MAX);

  // R6 R7
  p_preamble_low_r6: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(corrOn && inPreamble && inWord <= LOW_END) |-> outWord == '0);

  // R8
  p_no_flag_pass_r8: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(!inActive && !inPreamble) |-> outWord == $past(inWord));

  // R9 R10
  p_disabled_pass_r9: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(!corrOn) |-> outWord == $past(inWord));

endmodule

bind vid_code_remap vid_code_remap_chk #(
  .WORD_W       (WORD_W),
  .RESERVED_SPAN(RESERVED_SPAN)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .procEn      (procEn),
  .remapDisable(remapDisable),
  .inWord      (inWord),
  .inValid     (inValid),
  .inActive    (inActive),
  .inPreamble  (inPreamble),
  .outWord     (outWord),
  .outValid    (outValid),
  .outActive   (outActive),
  .outPreamble (outPreamble)
);

// File: tb/vid_code_remap_tb.sv
module vid_code_remap_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       procEn = 1'b0;
  logic       remapDisable = 1'b0;
  logic [9:0] inWord = '0;
  logic       inValid = 1'b0;
  logic       inActive = 1'b0;
  logic       inPreamble = 1'b0;
  logic [9:0] outWord;
  logic       outValid;
  logic       outActive;
  logic       outPreamble;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vid_code_remap u_dut (
    .clk(clk), .rstN(rstN), .procEn(procEn), .remapDisable(remapDisable),
    .inWord(inWord), .inValid(inValid), .inActive(inActive), .inPreamble(inPreamble),
    .outWord(outWord), .outValid(outValid), .outActive(outActive), .outPreamble(outPreamble)
  );

  typedef struct {
    logic [9:0] word;
    logic       vld;
    logic       act;
    logic       pre;
    string      tag;
  } expT;

  expT sb[$];

  function automatic logic [9:0] model(logic [9:0] w, logic act, logic pre, logic en, logic dis);
    logic on;
    on = en & ~dis;
    if (on && pre) begin
      if (w >= 10'h3FC) return 10'h3FF;
      if (w <= 10'h003) return 10'h000;
      return w;
    end
    if (on && act) begin
      if (w >= 10'h3FC) return 10'h3FB;
      if (w <= 10'h003) return 10'h004;
      return w;
    end
    return w;
  endfunction

  function automatic string tagFor(logic [9:0] w, logic act, logic pre, logic en, logic dis);
    if (!en) return "R10";
    if (dis) return "R9";
    if (pre && act) return "R7";
    if (pre) return (w >= 10'h3FC) ? "R5" : "R6";
    if (act) begin
      if (w >= 10'h3FC) return "R2";
      if (w <= 10'h003) return "R3";
      return "R4";
    end
    return "R8";
  endfunction

  task automatic drive(logic [9:0] w, logic vld, logic act, logic pre, logic en, logic dis);
    expT e;
    @(negedge clk);
    inWord = w; inValid = vld; inActive = act; inPreamble = pre;
    procEn = en; remapDisable = dis;
    e.word = model(w, act, pre, en, dis);
    e.vld = vld; e.act = act; e.pre = pre;
    e.tag = tagFor(w, act, pre, en, dis);
    sb.push_back(e);
  endtask

  task automatic sweep(logic act, logic pre, logic en, logic dis);
    for (int c = 0; c < 1024; c++) drive(10'(c), c[0] | act, act, pre, en, dis);
  endtask

  // Monitor: one expected item per cycle, sampled just after the edge.
  always @(posedge clk) begin
    #1;
    if (rstN && sb.size() > 0) begin
      expT e;
      e = sb.pop_front();
      checks++;
      if (outWord !== e.word) begin
        failures++;
        $display("FAIL %s word actual=%03h expected=%03h", e.tag, outWord, e.word);
      end
      checks++;
      if ({outValid, outActive, outPreamble} !== {e.vld, e.act, e.pre}) begin
        failures++;
        $display("FAIL R11 flags actual=%b%b%b expected=%b%b%b",
                 outValid, outActive, outPreamble, e.vld, e.act, e.pre);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    inWord = 10'h3FF; inValid = 1'b1; inActive = 1'b1; inPreamble = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    checks++;
    if ({outValid, outActive, outPreamble} !== 3'b000 || outWord !== 10'h000) begin
      failures++;
      $display("FAIL R1 actual=%b%b%b/%03h expected=000/000",
               outValid, outActive, outPreamble, outWord);
    end
    inValid = 1'b0; inActive = 1'b0; inPreamble = 1'b0; inWord = '0;
    rstN = 1'b1;

    sweep(1'b1, 1'b0, 1'b1, 1'b0);  // R2 R3 R4 active picture
    sweep(1'b0, 1'b1, 1'b1, 1'b0);  // R5 R6 preamble
    sweep(1'b1, 1'b1, 1'b1, 1'b0);  // R7 both flags
    sweep(1'b0, 1'b0, 1'b1, 1'b0);  // R8 no flags
    sweep(1'b1, 1'b0, 1'b1, 1'b1);  // R9 local disable
    sweep(1'b0, 1'b1, 1'b1, 1'b1);  // R9 local disable, preamble
    sweep(1'b1, 1'b1, 1'b0, 1'b0);  // R10 global off
    sweep(1'b1, 1'b0, 1'b0, 1'b1);  // R10 global off, bit high
    // R11: alternating flags cycle by cycle across band edges
    for (int k = 0; k < 64; k++)
      drive((k[1]) ? 10'h3FC + 10'(k % 4) : 10'(k % 8), k[0], k[1], k[2], 1'b1, k[3]);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule